// File: doc/BRIEF.md
# Tunnelled JTAG Bridge Controller

This block lets a host reach the scan chain of an external target device through the FPGA's own boundary-scan port. The FPGA's user-chain interface supplies two chain-select strobes, capture, shift and update strobes, the host TCK and the host TDI. The block returns TDO to that interface and drives the target's TCK, TMS and TDI pins. It samples the target's TDO.

The host first shifts a two-bit mode code through the first user chain. Every later access to the second user chain then does one of three things, depending on the mode:

- In the setup mode it reads and writes a 33-bit register that holds a transfer length and an end-of-shift flag.
- In the state-walk mode each host bit becomes a target TMS bit, so the host can move the target TAP between states.
- In the data mode each host bit goes to the target's data input while TMS stays low. On the last bit of the programmed length, TMS takes the stored flag, so the target leaves its shift state with no separate TMS access. The target's TDO bits come back to the host in the same order.

All registers run on the host TCK. The target clock is a gated copy of that TCK.

Top module: `jtag_tunnel_bridge`

## Requirements
- R1: The mode register is two bits wide and resets to setup (code 0). Codes are setup = 0, state-walk = 1 and data = 2. The code is shifted LSB first through the first chain and loads on that chain's update strobe. Code 3 leaves the mode unchanged. On capture of the first chain the current mode is loaded into its shift stage, so the old mode appears on TDO LSB first.
- R2: Shifting the first chain without an update strobe does not change the mode.
- R3: The setup register is 33 bits, shifted LSB first. Bits 31:0 hold the transfer length and bit 32 holds the end-of-shift flag. It loads on update of the second chain only in setup mode. Second-chain traffic in any other mode leaves it unchanged. It resets to zero.
- R4: On capture of the second chain in setup mode, the stored setup value is copied to the shift stage and then appears on TDO, bit 0 first.
- R5: In data mode, each host TDI bit is driven onto target TDI while the second chain shifts. Target TMS is low on every bit except the final one.
- R6: In data mode with length N > 0, target TMS equals the end-of-shift flag on bit N-1 (counting from 0). With N = 0 the flag applies to bit 0.
- R7: In data mode, target TDO is returned on the user-chain TDO, so the bit read back for each shifted bit is the target's current output. In state-walk mode, TDO is low while the second chain is selected.
- R8: In state-walk mode, target TMS equals host TDI while the second chain shifts, and target TDI is held low.
- R9: Target TCK follows host TCK only while the second chain is selected and shifting in state-walk or data mode. Otherwise target TCK, TMS and TDI are held low.
- R10: The bit counter clears on capture of the second chain and advances by one per TCK edge while that chain shifts. A second transfer therefore applies the final-bit rule afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Host scan clock from the user-chain interface |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_mode | input | 1 | First user chain selected |
| sel_data | input | 1 | Second user chain selected |
| capture | input | 1 | Capture strobe |
| shift | input | 1 | Shift strobe |
| update | input | 1 | Update strobe |
| tdi | input | 1 | Host serial data in |
| tdo | output | 1 | Serial data returned to the host |
| tgt_tck | output | 1 | Target scan clock |
| tgt_tms | output | 1 | Target mode select |
| tgt_tdi | output | 1 | Target serial data in |
| tgt_tdo | input | 1 | Target serial data out |

## Verification
Two things can happen on the same TCK edge: raising TMS on the final data bit, and passing data in both directions. The zero-length case makes this tightest, because the first bit of the transfer is also its last, so the counter clear on capture and the flag must act together. The bench provokes this by running a 16-bit data transfer with the flag set and, separately, a zero-length transfer run twice in a row. It judges every bit against a queue of expected TMS, target TDI, returned TDO and target clock values, and compares the model target's final register contents with the data that was shifted in.

// File: rtl/jtb_pkg.sv
`timescale 1ns/1ps
package jtb_pkg;
    typedef enum logic [1:0] {
        MODE_SETUP = 2'd0,
        MODE_WALK  = 2'd1,
        MODE_DATA  = 2'd2
    } jtb_mode_e;

    localparam logic [1:0] MODE_CODE_BAD = 2'd3;
endpackage

// File: rtl/jtb_mode_reg.sv
`timescale 1ns/1ps
module jtb_mode_reg
    import jtb_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sel,
    input  logic      capture,
    input  logic      shift,
    input  logic      update,
    input  logic      tdi,
    output jtb_mode_e mode_o,
    output logic      tdo_o
);
    typedef struct packed {
        logic [1:0] stage;
        jtb_mode_e  mode;
    } mode_st_t;

    mode_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sel) begin
            if (capture) begin
                st_d.stage = st_q.mode;
            end else if (shift) begin
                st_d.stage = {tdi, st_q.stage[1]};
            end else if (update && st_q.stage != MODE_CODE_BAD) begin
                st_d.mode = jtb_mode_e'(st_q.stage);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{stage: 2'd0, mode: MODE_SETUP};
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o = st_q.mode;
    assign tdo_o  = st_q.stage[0];

    // R2: mode changes only on an update of this chain
    a_r2_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel && update) |=> $stable(st_q.mode));

    // R1: the unused code never reaches the mode register
    a_r1_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.mode != MODE_CODE_BAD);
endmodule

// File: rtl/jtb_setup_reg.sv
`timescale 1ns/1ps
module jtb_setup_reg #(
    parameter int LEN_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             capture,
    input  logic             shift,
    input  logic             update,
    input  logic             tdi,
    output logic [LEN_W-1:0] len_o,
    output logic             flag_o,
    output logic             tdo_o
);
    localparam int REG_W = LEN_W + 1;

    typedef struct packed {
        logic [REG_W-1:0] stage;
        logic [REG_W-1:0] held;
    } setup_st_t;

    setup_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en) begin
            if (capture) begin
                st_d.stage = st_q.held;
            end else if (shift) begin
                st_d.stage = {tdi, st_q.stage[REG_W-1:1]};
            end else if (update) begin
                st_d.held = st_q.stage;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign len_o  = st_q.held[LEN_W-1:0];
    assign flag_o = st_q.held[LEN_W];
    assign tdo_o  = st_q.stage[0];

    // R3: stored setup changes only on update while enabled
    a_r3_setup_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(en && update) |=> $stable(st_q.held));

    // R4: capture presents the stored value for readback
    a_r4_capture_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (en && capture) |=> st_q.stage == $past(st_q.held));
endmodule

// File: rtl/jtb_bit_counter.sv
`timescale 1ns/1ps
module jtb_bit_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  logic             capture,
    input  logic             shift,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sel) begin
            if (capture) begin
                st_d.cnt = '0;
            end else if (shift && st_q.cnt != CNT_TOP) begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.cnt;

    // R10: capture clears the count
    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && capture) |=> st_q.cnt == '0);

    // R10: one step per shifted bit
    a_r10_step: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && shift && !capture && st_q.cnt != CNT_TOP)
        |=> st_q.cnt == $past(st_q.cnt) + CNT_W'(1));
endmodule

// File: rtl/jtag_tunnel_bridge.sv
`timescale 1ns/1ps
module jtag_tunnel_bridge
    import jtb_pkg::*;
#(
    parameter int LEN_W = 32
) (
    input  logic tck,
    input  logic rst_n,
    input  logic sel_mode,
    input  logic sel_data,
    input  logic capture,
    input  logic shift,
    input  logic update,
    input  logic tdi,
    output logic tdo,
    output logic tgt_tck,
    output logic tgt_tms,
    output logic tgt_tdi,
    input  logic tgt_tdo
);
    jtb_mode_e        mode;
    logic             mode_tdo;
    logic             setup_tdo;
    logic [LEN_W-1:0] xfer_len;
    logic             end_flag;
    logic [LEN_W-1:0] bit_cnt;
    logic             setup_en;
    logic             pass_en;
    logic             last_bit;
    logic [LEN_W-1:0] len_m1;

    assign setup_en = sel_data && (mode == MODE_SETUP);

    jtb_mode_reg u_mode (
        .clk     (tck),
        .rst_n   (rst_n),
        .sel     (sel_mode),
        .capture (capture),
        .shift   (shift),
        .update  (update),
        .tdi     (tdi),
        .mode_o  (mode),
        .tdo_o   (mode_tdo)
    );

    jtb_setup_reg #(.LEN_W(LEN_W)) u_setup (
        .clk     (tck),
        .rst_n   (rst_n),
        .en      (setup_en),
        .capture (capture),
        .shift   (shift),
        .update  (update),
        .tdi     (tdi),
        .len_o   (xfer_len),
        .flag_o  (end_flag),
        .tdo_o   (setup_tdo)
    );

    jtb_bit_counter #(.CNT_W(LEN_W)) u_count (
        .clk     (tck),
        .rst_n   (rst_n),
        .sel     (sel_data),
        .capture (capture),
        .shift   (shift),
        .count_o (bit_cnt)
    );

    always_comb begin
        len_m1   = xfer_len - LEN_W'(1);
        pass_en  = sel_data && shift && (mode == MODE_WALK || mode == MODE_DATA);
        last_bit = (xfer_len == '0) ? (bit_cnt == '0) : (bit_cnt == len_m1);

        tgt_tms = 1'b0;
        tgt_tdi = 1'b0;
        if (pass_en) begin
            if (mode == MODE_WALK) begin
                tgt_tms = tdi;
            end else begin
                tgt_tdi = tdi;
                tgt_tms = last_bit && end_flag;
            end
        end

        if (sel_mode) begin
            tdo = mode_tdo;
        end else if (setup_en) begin
            tdo = setup_tdo;
        end else if (sel_data && mode == MODE_DATA) begin
            tdo = tgt_tdo;
        end else begin
            tdo = 1'b0;
        end
    end

    // strobes change while tck is low, so the gate opens and closes cleanly
    assign tgt_tck = tck && pass_en;

    // R5: TMS low on data bits before the final one
    a_r5_tms_low: assert property (@(posedge tck) disable iff (!rst_n)
        (sel_data && shift && mode == MODE_DATA && xfer_len != '0
         && bit_cnt < len_m1) |-> !tgt_tms);

    // R9: target pins idle when nothing is passed through
    a_r9_pins_idle: assert property (@(posedge tck) disable iff (!rst_n)
        !(sel_data && shift) |-> (!tgt_tms && !tgt_tdi));

    // R8: walk mode never drives target data
    a_r8_walk_tdi: assert property (@(posedge tck) disable iff (!rst_n)
        (mode == MODE_WALK) |-> !tgt_tdi);
endmodule

// File: tb/sim_jtag_tunnel_bridge.sv
`timescale 1ns/1ps
module sim_jtag_tunnel_bridge;
    logic tck = 1'b0;
    always #2 tck = ~tck;

    logic rst_n = 1'b0;
    logic sel_mode = 1'b0, sel_data = 1'b0;
    logic capture = 1'b0, shift = 1'b0, update = 1'b0, tdi = 1'b0;
    logic tdo, tgt_tck, tgt_tms, tgt_tdi, tgt_tdo;

    jtag_tunnel_bridge u0 (
        .tck(tck), .rst_n(rst_n), .sel_mode(sel_mode), .sel_data(sel_data),
        .capture(capture), .shift(shift), .update(update), .tdi(tdi),
        .tdo(tdo), .tgt_tck(tgt_tck), .tgt_tms(tgt_tms), .tgt_tdi(tgt_tdi),
        .tgt_tdo(tgt_tdo)
    );

    // simple target: 16-bit shift register, LSB out
    logic [15:0] tsr;
    logic [15:0] tinit = 16'h0;
    logic        tload = 1'b0;
    always @(posedge tgt_tck or posedge tload) begin
        if (tload) tsr <= tinit;
        else       tsr <= {tgt_tdi, tsr[15:1]};
    end
    assign tgt_tdo = tsr[0];

    typedef struct {
        logic [2:0] pins;   // {tdo, tgt_tms, tgt_tdi}
        logic       ck;
        string      tag;
    } item_t;

    item_t sb_q[$];
    int n_checks = 0;
    int n_fail = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // monitor: compare just before the capturing edge, clock while high
    initial begin
        item_t it;
        forever begin
            @(negedge tck);
            #1;
            if (sb_q.size() > 0) begin
                it = sb_q.pop_front();
                chk({it.tag, " pins"}, {29'd0, tdo, tgt_tms, tgt_tdi}, {29'd0, it.pins});
                #2;
                chk({it.tag, " tgt_tck"}, {31'd0, tgt_tck}, {31'd0, it.ck});
            end
        end
    end

    task automatic preload(input logic [15:0] v);
        tinit = v;
        tload = 1'b1;
        #0.5;
        tload = 1'b0;
    endtask

    task automatic jscan(input bit data_chain, input int n, input logic [39:0] din,
                         input logic [39:0] e_tdo, input logic [39:0] e_tms,
                         input logic [39:0] e_tdi, input bit e_ck,
                         input bit do_upd, input string tag);
        item_t it;
        @(negedge tck);
        sel_mode = !data_chain;
        sel_data = data_chain;
        capture  = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge tck);
            capture = 1'b0;
            shift   = 1'b1;
            tdi     = din[i];
            it.pins = {e_tdo[i], e_tms[i], e_tdi[i]};
            it.ck   = e_ck;
            it.tag  = tag;
            sb_q.push_back(it);
        end
        @(negedge tck);
        shift  = 1'b0;
        tdi    = 1'b0;
        update = do_upd;
        @(negedge tck);
        update   = 1'b0;
        sel_mode = 1'b0;
        sel_data = 1'b0;
    endtask

    task automatic drain;
        while (sb_q.size() > 0) @(negedge tck);
        @(negedge tck);
    endtask

    task automatic finish_up;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(4 * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual hung expected done");
        finish_up();
    end

    initial begin
        preload(16'h0);
        repeat (3) @(negedge tck);
        #1;
        // R9 reset state: all target pins idle, tdo low
        chk("R9 reset pins", {28'd0, tdo, tgt_tck, tgt_tms, tgt_tdi}, 32'd0);
        rst_n = 1'b1;

        // R1: reset mode reads back as setup (0)
        jscan(0, 2, 40'd0, 40'd0, 40'd0, 40'd0, 0, 1, "R1 reset mode");
        // R4: write length 16 flag 1, old value reads as zero
        jscan(1, 33, {7'd0, 1'b1, 32'd16}, 40'd0, 40'd0, 40'd0, 0, 1, "R4 setup write");
        // R4: readback of stored value
        jscan(1, 33, {7'd0, 1'b1, 32'd16}, {7'd0, 1'b1, 32'd16}, 40'd0, 40'd0, 0, 1, "R4 setup readback");
        // R1: select data mode (code 2)
        jscan(0, 2, 40'd2, 40'd0, 40'd0, 40'd0, 0, 1, "R1 to data");
        drain();

        // R5 R6 R7: 16-bit data transfer, flag on bit 15
        preload(16'h1234);
        jscan(1, 16, 40'hA5C3, 40'h1234, 40'h8000, 40'hA5C3, 1, 1, "R5 R6 R7 data run");
        drain();
        chk("R5 target contents", {16'd0, tsr}, 32'h0000A5C3);

        // R1: select walk mode, old mode 2 reads back
        jscan(0, 2, 40'd1, 40'd2, 40'd0, 40'd0, 0, 1, "R1 to walk");
        // R8 R7 R9: TMS bits 1,1,0,1 passed through
        jscan(1, 4, 40'hB, 40'd0, 40'hB, 40'd0, 1, 1, "R8 walk run");
        // R3: second-chain traffic outside setup mode
        jscan(1, 33, 40'd0, 40'd0, 40'd0, 40'd0, 1, 1, "R3 walk traffic");
        // R2: shift code 2 without update
        jscan(0, 2, 40'd2, 40'd1, 40'd0, 40'd0, 0, 0, "R2 no update");
        // R2: mode still walk (1)
        jscan(0, 2, 40'd3, 40'd1, 40'd0, 40'd0, 0, 1, "R2 mode kept");
        // R1: code 3 above ignored, still walk; now load setup
        jscan(0, 2, 40'd0, 40'd1, 40'd0, 40'd0, 0, 1, "R1 code 3 ignored");
        // R3: setup unchanged by walk traffic; write length 0 flag 1
        jscan(1, 33, {7'd0, 1'b1, 32'd0}, {7'd0, 1'b1, 32'd16}, 40'd0, 40'd0, 0, 1, "R3 setup kept");
        jscan(0, 2, 40'd2, 40'd0, 40'd0, 40'd0, 0, 1, "R1 to data again");
        drain();

        // R6: zero length, flag applies to bit 0
        preload(16'h0005);
        jscan(1, 3, 40'h6, 40'h5, 40'h1, 40'h6, 1, 1, "R6 zero length");
        drain();
        // R10: counter cleared on next capture, bit 0 again final
        preload(16'h0002);
        jscan(1, 3, 40'h1, 40'h2, 40'h1, 40'h1, 1, 1, "R10 second run");
        drain();
        #1;
        chk("R9 idle after run", {29'd0, tgt_tck, tgt_tms, tgt_tdi}, 32'd0);

        finish_up();
    end
endmodule